// File: doc/BRIEF.md
# Receive Frame Length Checker

This block sits on the receive byte path of an Ethernet MAC. Once the start frame delimiter has been stripped, it counts every accepted byte of a frame, from the first marked byte through the last. The count is compared against two programmable limits, an upper and a lower frame length. A typical setting is an upper limit of 1518 and a lower limit of 64.

A frame that grows past the upper limit is still delivered in full. A live sticky flag warns downstream logic as soon as the limit is crossed, and the final status marks the frame as long. A frame that ends below the lower limit is normally thrown away: a one-cycle drop pulse tells the buffer logic to roll back the bytes it has already stored. When short-frame retention is enabled, such a frame is kept and flagged as short instead.

The verdict, the flags and the final length appear together for one cycle, the cycle after the last byte is accepted. They are meant to be written with the frame's last receive descriptor.

Top module: `rx_len_guard`

## Requirements
- R1: `res_len` in the verdict cycle equals the number of accepted bytes of the frame, counting both the start-marked byte and the end-marked byte. A byte is accepted when `byte_vld` is high and either `frm_first` is high or a frame is open.
- R2: Each completed frame produces exactly one verdict cycle: the cycle after its end-marked byte is accepted, in which exactly one of `res_keep` and `res_drop` is high. Outside verdict cycles `res_keep`, `res_drop`, `res_long`, `res_short` and `res_len` are all zero.
- R3: `res_long` is 1 in the verdict cycle exactly when the running count exceeded `len_max` on at least one byte of the frame. A long frame that is not short is kept (`res_keep` = 1).
- R4: `over_live` goes high in the cycle after the first byte whose running count exceeds `len_max`. It stays high until the frame's end-marked byte or a new start-marked byte is accepted, and it is low whenever no frame is open.
- R5: If the final length is below `len_min` and `keep_short` = 0, the verdict is `res_drop` = 1 with `res_keep` = 0 and `res_short` = 0.
- R6: If the final length is below `len_min` and `keep_short` = 1, the verdict is `res_keep` = 1 with `res_short` = 1. `res_short` is never 1 for a frame whose length is at least `len_min`.
- R7: The running count saturates at 2^LEN_W-1 (65535 by default), so a longer frame reports exactly that length and never wraps.
- R8: Cycles with `byte_vld` = 0 leave the count unchanged. Bytes and end markers that arrive while no frame is open are ignored and produce no verdict.
- R9: A start-marked byte that arrives while a frame is open abandons that frame without any verdict, and it becomes byte 1 of a new frame.
- R10: After reset, no frame is open and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| frm_first | input | 1 | The present byte is the first byte after the delimiter |
| frm_last | input | 1 | The present byte is the final byte of the frame |
| len_max | input | LEN_W | Upper length limit; a count above it marks the frame long |
| len_min | input | LEN_W | Lower length limit; a final length below it marks the frame short |
| keep_short | input | 1 | 1: keep and flag short frames; 0: drop them |
| over_live | output | 1 | Sticky: the open frame has already passed `len_max` |
| res_keep | output | 1 | One-cycle pulse: the frame is kept |
| res_drop | output | 1 | One-cycle pulse: the frame is discarded and its bytes are to be rolled back |
| res_long | output | 1 | Long-frame flag, valid in the verdict cycle |
| res_short | output | 1 | Short-frame flag, valid in the verdict cycle |
| res_len | output | LEN_W | Final frame length, valid in the verdict cycle |

## Verification
Every state register in this block becomes visible within a frame's length. A wrong count or a lost saturation shows up in `res_len` in the verdict cycle right after the end byte. A wrong sticky over-limit bit is visible at once on `over_live`, the cycle after the offending byte. A wrong open-frame bit shows up either as a verdict for a stray end marker or as a missing verdict for a real frame. The bench therefore compares every output against a behavioural model on every clock. It drives frames at and around both limits, with and without idle gaps, plus stray bytes, restarts, back-to-back frames and one frame long enough to saturate, so a divergence is caught in the cycle it first appears.

// File: rtl/rxlg_pkg.sv
package rxlg_pkg;
   // Customary limit values for standard frames
   localparam int unsigned RXLG_TYPICAL_MAX = 1518;
   localparam int unsigned RXLG_TYPICAL_MIN = 64;

   typedef enum logic [1:0] {
      VERDICT_NONE = 2'b00,
      VERDICT_KEEP = 2'b01,
      VERDICT_DROP = 2'b10
   } verdict_e;
endpackage

// File: rtl/rxlg_beat_track.sv
module rxlg_beat_track #(
   parameter int unsigned LEN_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             frm_first,
   input  logic             frm_last,
   output logic             accept,
   output logic             last_beat,
   output logic [LEN_W-1:0] cnt_nx
);
   localparam logic [LEN_W-1:0] CNT_TOP = {LEN_W{1'b1}};

   logic             open_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] base;

   assign accept    = byte_vld && (frm_first || open_q);
   assign last_beat = accept && frm_last;
   assign base      = frm_first ? '0 : cnt_q;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nx = (base == CNT_TOP) ? base : base + 1'b1;
      end else begin : g_wrap
         assign cnt_nx = base + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept) begin
         open_q <= !frm_last;
         cnt_q  <= frm_last ? '0 : cnt_nx;
      end
   end
endmodule

// File: rtl/rxlg_over_track.sv
module rxlg_over_track #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             frm_first,
   input  logic             frm_last,
   input  logic [LEN_W-1:0] cnt_nx,
   input  logic [LEN_W-1:0] len_max,
   output logic             over_nx,
   output logic             over_live
);
   logic over_q;

   assign over_nx   = (!frm_first && over_q) || (cnt_nx > len_max);
   assign over_live = over_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         over_q <= 1'b0;
      end else if (accept) begin
         over_q <= frm_last ? 1'b0 : over_nx;
      end
   end
endmodule

// File: rtl/rxlg_verdict.sv
module rxlg_verdict
   import rxlg_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last_beat,
   input  logic [LEN_W-1:0] cnt_nx,
   input  logic             over_nx,
   input  logic [LEN_W-1:0] len_min,
   input  logic             keep_short,
   output logic             res_keep,
   output logic             res_drop,
   output logic             res_long,
   output logic             res_short,
   output logic [LEN_W-1:0] res_len
);
   logic     is_short;
   verdict_e verdict_d;
   verdict_e verdict_q;

   assign is_short = cnt_nx < len_min;

   always_comb begin
      verdict_d = VERDICT_NONE;
      if (last_beat) begin
         verdict_d = (is_short && !keep_short) ? VERDICT_DROP : VERDICT_KEEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_q <= VERDICT_NONE;
         res_long  <= 1'b0;
         res_short <= 1'b0;
         res_len   <= '0;
      end else begin
         verdict_q <= verdict_d;
         res_long  <= last_beat && over_nx;
         res_short <= last_beat && is_short && keep_short;
         res_len   <= last_beat ? cnt_nx : '0;
      end
   end

   assign res_keep = (verdict_q == VERDICT_KEEP);
   assign res_drop = (verdict_q == VERDICT_DROP);
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard #(
   parameter int unsigned LEN_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             frm_first,
   input  logic             frm_last,
   input  logic [LEN_W-1:0] len_max,
   input  logic [LEN_W-1:0] len_min,
   input  logic             keep_short,
   output logic             over_live,
   output logic             res_keep,
   output logic             res_drop,
   output logic             res_long,
   output logic             res_short,
   output logic [LEN_W-1:0] res_len
);
   // The width must hold the customary maximum frame length
   generate
      if (LEN_W < 11 || LEN_W > 32) begin : g_bad_width
         $error("rx_len_guard: LEN_W must lie in 11..32");
      end
   endgenerate

   logic             accept;
   logic             last_beat;
   logic             over_nx;
   logic [LEN_W-1:0] cnt_nx;

   rxlg_beat_track #(.LEN_W(LEN_W), .SATURATE(SATURATE)) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .frm_first (frm_first),
      .frm_last  (frm_last),
      .accept    (accept),
      .last_beat (last_beat),
      .cnt_nx    (cnt_nx)
   );

   rxlg_over_track #(.LEN_W(LEN_W)) u_over (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .frm_first (frm_first),
      .frm_last  (frm_last),
      .cnt_nx    (cnt_nx),
      .len_max   (len_max),
      .over_nx   (over_nx),
      .over_live (over_live)
   );

   rxlg_verdict #(.LEN_W(LEN_W)) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .last_beat  (last_beat),
      .cnt_nx     (cnt_nx),
      .over_nx    (over_nx),
      .len_min    (len_min),
      .keep_short (keep_short),
      .res_keep   (res_keep),
      .res_drop   (res_drop),
      .res_long   (res_long),
      .res_short  (res_short),
      .res_len    (res_len)
   );
endmodule

// File: rtl/rx_len_guard_chk.sv
module rx_len_guard_chk #(
   parameter int unsigned LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_vld,
   input logic             frm_first,
   input logic             frm_last,
   input logic [LEN_W-1:0] len_max,
   input logic             keep_short,
   input logic             over_live,
   input logic             res_keep,
   input logic             res_drop,
   input logic             res_long,
   input logic             res_short,
   input logic [LEN_W-1:0] res_len
);
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_keep && res_drop)); // R2

   AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (res_keep || res_drop) |-> $past(byte_vld && frm_last)); // R2

   AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_keep || res_drop) |-> (res_len == '0 && !res_long && !res_short)); // R2

   AST_NOT_LONG_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_keep && !res_long) |-> (res_len <= $past(len_max))); // R3

   AST_SHORT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_short |-> (res_keep && $past(keep_short))); // R6

   AST_LEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_keep || res_drop) |-> (res_len != '0)); // R7

   AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(over_live) |-> $past(byte_vld && (frm_last || frm_first))); // R4
endmodule

bind rx_len_guard rx_len_guard_chk #(.LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_vld   (byte_vld),
   .frm_first  (frm_first),
   .frm_last   (frm_last),
   .len_max    (len_max),
   .keep_short (keep_short),
   .over_live  (over_live),
   .res_keep   (res_keep),
   .res_drop   (res_drop),
   .res_long   (res_long),
   .res_short  (res_short),
   .res_len    (res_len)
);

// File: tb/test_rx_len_guard.sv
`timescale 1ns/1ps
module test_rx_len_guard;
   localparam int LW  = 16;
   localparam int TOP = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_vld = 1'b0;
   logic          frm_first = 1'b0;
   logic          frm_last = 1'b0;
   logic [LW-1:0] len_max = 16'd1518;
   logic [LW-1:0] len_min = 16'd64;
   logic          keep_short = 1'b0;
   logic          over_live, res_keep, res_drop, res_long, res_short;
   logic [LW-1:0] res_len;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #2 clk = ~clk;

   rx_len_guard #(.LEN_W(LW)) i_rx_len_guard (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frm_first(frm_first),
      .frm_last(frm_last), .len_max(len_max), .len_min(len_min),
      .keep_short(keep_short), .over_live(over_live), .res_keep(res_keep),
      .res_drop(res_drop), .res_long(res_long), .res_short(res_short),
      .res_len(res_len)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced on every rising edge
   bit m_open = 0;
   int m_cnt  = 0;
   bit m_over = 0;
   bit e_keep = 0, e_drop = 0, e_long = 0, e_short = 0;
   int e_len  = 0;

   always @(posedge clk) begin
      cyc++;
      e_keep = 0; e_drop = 0; e_long = 0; e_short = 0; e_len = 0;
      if (!rst_n) begin
         m_open = 0; m_cnt = 0; m_over = 0;
      end else if (byte_vld && (frm_first || m_open)) begin
         int n;
         bit ov;
         if (frm_first) begin n = 1; ov = 0; end
         else begin n = (m_cnt < TOP) ? m_cnt + 1 : TOP; ov = m_over; end
         if (n > int'(len_max)) ov = 1;
         if (frm_last) begin
            bit sh;
            sh = n < int'(len_min);
            e_drop = sh && !keep_short;
            e_keep = !e_drop;
            e_short = sh && keep_short;
            e_long = ov;
            e_len = n;
            m_open = 0; m_cnt = 0; m_over = 0;
         end else begin
            m_open = 1; m_cnt = n; m_over = ov;
         end
      end
   end

   // Per-cycle comparison and verdict capture, away from the edge
   int obs_n = 0;
   bit obs_keep, obs_drop, obs_long, obs_short;
   int obs_len;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(res_keep == e_keep,   "R2 res_keep",  res_keep,  e_keep);
         chk(res_drop == e_drop,   "R5 res_drop",  res_drop,  e_drop);
         chk(res_long == e_long,   "R3 res_long",  res_long,  e_long);
         chk(res_short == e_short, "R6 res_short", res_short, e_short);
         chk(int'(res_len) == e_len, "R1 res_len", res_len,   e_len);
         chk(over_live == m_over,  "R4 over_live", over_live, m_over);
         if (res_keep || res_drop) begin
            obs_n++;
            obs_keep = res_keep; obs_drop = res_drop; obs_long = res_long;
            obs_short = res_short; obs_len = res_len;
         end
      end
      if (cyc >= 190000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_vld = 0; frm_first = 0; frm_last = 0;
      end
   endtask

   task automatic beat(input bit f, input bit l);
      @(negedge clk);
      byte_vld = 1; frm_first = f; frm_last = l;
   endtask

   task automatic send(input int len, input int gap, input bit close);
      for (int i = 0; i < len; i++) begin
         beat(i == 0, close && (i == len - 1));
         if (gap > 0 && (i % gap) == gap - 1) idle(1);
      end
   endtask

   task automatic expect_one(input int base_n, input bit k, input bit lg,
                             input bit sh, input int len, input string tag);
      chk(obs_n == base_n + 1, {tag, " verdict count"}, obs_n - base_n, 1);
      chk(obs_keep == k && obs_drop == !k, {tag, " keep"}, obs_keep, k);
      chk(obs_long == lg, {tag, " long"}, obs_long, lg);
      chk(obs_short == sh, {tag, " short"}, obs_short, sh);
      chk(obs_len == len, {tag, " length"}, obs_len, len);
   endtask

   initial begin
      int b;
      idle(3);
      chk(!res_keep && !res_drop && !over_live && res_len == 0, "R10 reset outputs", res_len, 0);
      @(negedge clk); rst_n = 1;
      idle(2);
      chk(!res_keep && !res_drop && !over_live, "R10 idle after reset", res_keep, 0);

      b = obs_n; send(64, 0, 1); idle(3);
      expect_one(b, 1, 0, 0, 64, "R1 exact minimum");
      b = obs_n; send(63, 5, 1); idle(3);
      expect_one(b, 0, 0, 0, 63, "R5 short dropped");
      keep_short = 1;
      b = obs_n; send(63, 0, 1); idle(3);
      expect_one(b, 1, 0, 1, 63, "R6 short kept");
      keep_short = 0;
      b = obs_n; send(1518, 0, 1); idle(3);
      expect_one(b, 1, 0, 0, 1518, "R3 exact maximum");
      b = obs_n; send(1519, 7, 1); idle(3);
      expect_one(b, 1, 1, 0, 1519, "R3 one over maximum");

      len_max = 20; len_min = 4;
      b = obs_n; send(30, 3, 1); idle(3);
      expect_one(b, 1, 1, 0, 30, "R4 small limits long");

      // R8: stray bytes and end marker with no open frame
      b = obs_n;
      beat(0, 0); beat(0, 0); beat(0, 1); idle(3);
      chk(obs_n == b, "R8 stray bytes ignored", obs_n - b, 0);

      // R9: restart abandons the open frame
      b = obs_n; send(25, 0, 0); send(5, 2, 1); idle(3);
      expect_one(b, 1, 0, 0, 5, "R9 restart");

      // R2: back-to-back frames with no idle between
      b = obs_n; send(6, 0, 1); send(22, 0, 1); idle(3);
      chk(obs_n == b + 2, "R2 back-to-back count", obs_n - b, 2);
      chk(obs_len == 22 && obs_long == 1, "R2 second frame", obs_len, 22);

      len_min = 1;
      b = obs_n; beat(1, 1); idle(3);
      expect_one(b, 1, 0, 0, 1, "R1 single byte");
      len_min = 64;
      b = obs_n; beat(1, 1); idle(3);
      expect_one(b, 0, 0, 0, 1, "R5 single byte dropped");

      len_max = 16'hFFFF;
      b = obs_n; send(65600, 0, 1); idle(3);
      expect_one(b, 1, 0, 0, 65535, "R7 saturation");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule